// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines and drives two processor-facing requests from it: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each pending bit follows its input line directly. Nothing is latched, so a line that drops also drops its pending bit. Each output has its own enable mask. An output asserts when at least one pending line is also enabled in that output's mask. Both outputs come from a flop and follow a change of input or enable one clock later.

Software reaches the block through a small word-addressed register port. Enables change only through separate set and clear words: a one sets or clears that bit, and a zero leaves it as it is. Software can also hold line 0 high itself through a set word and a clear word. For each output, software can read the raw pending vector and the masked status.

The request port has no back-pressure. A request is taken in every cycle where `req_valid` is high. A read returns its data with `rsp_valid` on the next cycle, and that response cannot be stalled. A write produces no response.

Top module: `lic_dual_ctrl`

## Requirements
- R1: Pending bit i equals `irq_lines[i]` in the same cycle, with no latching. Pending bit 0 is `irq_lines[0]` ORed with the software line-0 flag. Reads of word 1 and word 9 both return the pending vector.
- R2: `irq_o` equals the OR of (pending AND normal enables), as registered at the previous rising edge.
- R3: `fiq_o` equals the OR of (pending AND fast enables), as registered at the previous rising edge.
- R4: A write to word 2 ORs the write data into the normal enables, and a write to word 3 clears the normal enable bits where the data has ones. Words 10 and 11 do the same for the fast enables. Reads of word 2 and word 10 return the normal and fast enables.
- R5: A read of word 0 returns pending AND normal enables. A read of word 8 returns pending AND fast enables.
- R6: A write to word 4 with data bit 0 set sets the software line-0 flag. A write to word 5 with data bit 0 set clears it. Any other data bits in these writes are ignored, and a read of word 4 returns zero with no error.
- R7: A read of a write-only word (3, 5, 11) or of an unassigned word (6, 7, 12 to 15) returns zero with `rsp_err` high for that one response. A write to a read-only word (0, 1, 8, 9) or to an unassigned word changes no state.
- R8: While `rst_n` is low, both enable masks, the software flag, both outputs and all response outputs are cleared to zero.
- R9: Each read request produces exactly one response, with `rsp_valid` high in the next cycle. A write request never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N_LINES | Level interrupt inputs |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | N_LINES | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | N_LINES | Read data |
| rsp_err | output | 1 | Read hit a bad offset |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The embedded assertions check these properties on every cycle:
- a set or clear write lands in its mask on the next cycle;
- a mask holds its value when it is not written;
- an output never rises without an enable behind it;
- every response traces back to a read request;
- every error response carries zero data.

Some behaviour is only shown by the bench scenarios:
- the exact decode of all sixteen words, for both read and write;
- the per-line behaviour of the two masks, walking each of the 32 lines;
- the OR of the software flag with hardware line 0;
- the absence of side effects from bad writes.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int unsigned W_IRQ_STAT = 0;
  localparam int unsigned W_RAW_A    = 1;
  localparam int unsigned W_IRQ_SET  = 2;
  localparam int unsigned W_IRQ_CLR  = 3;
  localparam int unsigned W_SW_SET   = 4;
  localparam int unsigned W_SW_CLR   = 5;
  localparam int unsigned W_FIQ_STAT = 8;
  localparam int unsigned W_RAW_B    = 9;
  localparam int unsigned W_FIQ_SET  = 10;
  localparam int unsigned W_FIQ_CLR  = 11;

  localparam int unsigned N_CHAN = 2;

  typedef struct packed {
    logic irq_set;
    logic irq_clr;
    logic fiq_set;
    logic fiq_clr;
    logic sw_set;
    logic sw_clr;
  } wr_stb_t;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_IRQ_STAT,
    RS_RAW,
    RS_IRQ_EN,
    RS_FIQ_STAT,
    RS_FIQ_EN
  } rd_sel_t;

endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output wr_stb_t           stb,
  output rd_sel_t           rsel,
  output logic              rd_go,
  output logic              rd_bad
);

  logic wr_go;

  always_comb begin
    wr_go  = req_valid && req_write;
    rd_go  = req_valid && !req_write;
    stb    = '0;
    rsel   = RS_ZERO;
    rd_bad = 1'b0;
    if (wr_go) begin
      unique case (req_addr)
        ADDR_W'(W_IRQ_SET): stb.irq_set = 1'b1;
        ADDR_W'(W_IRQ_CLR): stb.irq_clr = 1'b1;
        ADDR_W'(W_FIQ_SET): stb.fiq_set = 1'b1;
        ADDR_W'(W_FIQ_CLR): stb.fiq_clr = 1'b1;
        ADDR_W'(W_SW_SET):  stb.sw_set  = 1'b1;
        ADDR_W'(W_SW_CLR):  stb.sw_clr  = 1'b1;
        default:            stb         = '0;
      endcase
    end
    if (rd_go) begin
      unique case (req_addr)
        ADDR_W'(W_IRQ_STAT): rsel = RS_IRQ_STAT;
        ADDR_W'(W_RAW_A):    rsel = RS_RAW;
        ADDR_W'(W_IRQ_SET):  rsel = RS_IRQ_EN;
        ADDR_W'(W_SW_SET):   rsel = RS_ZERO;
        ADDR_W'(W_FIQ_STAT): rsel = RS_FIQ_STAT;
        ADDR_W'(W_RAW_B):    rsel = RS_RAW;
        ADDR_W'(W_FIQ_SET):  rsel = RS_FIQ_EN;
        default:             rd_bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/lic_mask.sv
module lic_mask #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_stb,
  input  logic               clr_stb,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] en
);

  always_ff @(posedge clk) begin
    if (!rst_n)       en <= '0;
    else if (set_stb) en <= en | wdata;
    else if (clr_stb) en <= en & ~wdata;
  end

  // R4: set bits land on the next cycle
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en & $past(wdata)) == $past(wdata)));
  // R4: clear bits land on the next cycle
  a_r4_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en & $past(wdata)) == '0));
  // R4: no write, no change
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(en));

endmodule

// File: rtl/lic_outstage.sv
module lic_outstage #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend,
  input  logic [N_LINES-1:0] en,
  output logic [N_LINES-1:0] masked,
  output logic               req_q
);

  always_comb masked = pend & en;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= |masked;
  end

  // R2 / R3: an asserted output always had an enable behind it
  a_r2_out_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(en != '0));

endmodule

// File: rtl/lic_dual_ctrl.sv
module lic_dual_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [N_LINES-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [N_LINES-1:0] rsp_rdata,
  output logic               rsp_err,
  output logic               irq_o,
  output logic               fiq_o
);

  wr_stb_t            stb;
  rd_sel_t            rsel;
  logic               rd_go;
  logic               rd_bad;
  logic               sw_q;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] en_v     [N_CHAN];
  logic [N_LINES-1:0] masked_v [N_CHAN];
  logic               out_v    [N_CHAN];
  logic               set_v    [N_CHAN];
  logic               clr_v    [N_CHAN];
  logic [N_LINES-1:0] rd_mux;

  lic_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .stb       (stb),
    .rsel      (rsel),
    .rd_go     (rd_go),
    .rd_bad    (rd_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                         sw_q <= 1'b0;
    else if (stb.sw_set && req_wdata[0]) sw_q <= 1'b1;
    else if (stb.sw_clr && req_wdata[0]) sw_q <= 1'b0;
  end

  always_comb begin
    pend    = irq_lines;
    pend[0] = irq_lines[0] | sw_q;
  end

  always_comb begin
    set_v[0] = stb.irq_set;
    clr_v[0] = stb.irq_clr;
    set_v[1] = stb.fiq_set;
    clr_v[1] = stb.fiq_clr;
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    lic_mask #(.N_LINES(N_LINES)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_v[c]),
      .clr_stb (clr_v[c]),
      .wdata   (req_wdata),
      .en      (en_v[c])
    );
    lic_outstage #(.N_LINES(N_LINES)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend   (pend),
      .en     (en_v[c]),
      .masked (masked_v[c]),
      .req_q  (out_v[c])
    );
  end

  assign irq_o = out_v[0];
  assign fiq_o = out_v[1];

  always_comb begin
    unique case (rsel)
      RS_IRQ_STAT: rd_mux = masked_v[0];
      RS_RAW:      rd_mux = pend;
      RS_IRQ_EN:   rd_mux = en_v[0];
      RS_FIQ_STAT: rd_mux = masked_v[1];
      RS_FIQ_EN:   rd_mux = en_v[1];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      rsp_err   <= rd_go && rd_bad;
      rsp_rdata <= rd_go ? rd_mux : '0;
    end
  end

  // R9: a response only follows a read request
  a_r9_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R9: a read request is always answered next cycle
  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R7: an error response carries zero data
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  // R6: a software set of line 0 shows as pending on the next cycle
  a_r6_sw_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(W_SW_SET) && req_wdata[0])
      |=> pend[0]);

endmodule

// File: tb/tb_lic_dual_ctrl.sv
module tb_lic_dual_ctrl;

  localparam int N = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_lines = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [N-1:0]  req_wdata = '0;
  logic          rsp_valid;
  logic [N-1:0]  rsp_rdata;
  logic          rsp_err;
  logic          irq_o;
  logic          fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_irq_en = '0;
  logic [N-1:0] m_fiq_en = '0;
  logic         m_sw = 1'b0;

  always #10 clk = ~clk;

  lic_dual_ctrl #(.N_LINES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pend_m();
    logic [N-1:0] p;
    p = irq_lines;
    p[0] = p[0] | m_sw;
    return p;
  endfunction

  function automatic logic [N:0] exp_rd(input int a);
    case (a)
      0:       return {1'b0, m_irq_en & pend_m()};
      1, 9:    return {1'b0, pend_m()};
      2:       return {1'b0, m_irq_en};
      4:       return {1'b0, {N{1'b0}}};
      8:       return {1'b0, m_fiq_en & pend_m()};
      10:      return {1'b0, m_fiq_en};
      default: return {1'b1, {N{1'b0}}};
    endcase
  endfunction

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R9 no response to write", {31'd0, rsp_valid}, '0);
    case (a)
      2:  m_irq_en = m_irq_en | d;
      3:  m_irq_en = m_irq_en & ~d;
      10: m_fiq_en = m_fiq_en | d;
      11: m_fiq_en = m_fiq_en & ~d;
      4:  if (d[0]) m_sw = 1'b1;
      5:  if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [N:0] e;
    e = exp_rd(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R9 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " data"}, rsp_rdata, e[N-1:0]);
    check({req, " R7 err flag"}, {31'd0, rsp_err}, {31'd0, e[N]});
  endtask

  task automatic out_chk(input string tag);
    @(negedge clk);
    @(negedge clk);
    check({tag, " R2 irq_o"}, {31'd0, irq_o}, {31'd0, |(pend_m() & m_irq_en)});
    check({tag, " R3 fiq_o"}, {31'd0, fiq_o}, {31'd0, |(pend_m() & m_fiq_en)});
  endtask

  function automatic logic [N-1:0] xs(input logic [N-1:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] seed;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 irq_o reset", {31'd0, irq_o}, '0);
    check("R8 fiq_o reset", {31'd0, fiq_o}, '0);
    check("R8 rsp_valid reset", {31'd0, rsp_valid}, '0);
    rst_n = 1'b1;
    rd_chk(2, "R8 irq enables zero");
    rd_chk(10, "R8 fiq enables zero");

    // R1 walking line with each mask arrangement
    for (int i = 0; i < N; i++) begin
      irq_lines = N'(1) << i;
      rd_chk(1, "R1 raw walk");
      rd_chk(9, "R1 raw walk alias");
      out_chk("R1 none enabled");
      wr(2, N'(1) << i);
      rd_chk(0, "R5 irq status walk");
      out_chk("R4 irq only");
      wr(10, N'(1) << i);
      wr(3, N'(1) << i);
      rd_chk(8, "R5 fiq status walk");
      out_chk("R4 fiq only");
      wr(11, N'(1) << i);
      irq_lines = '0;
      out_chk("R1 line drop");
    end

    // R6 software line 0
    wr(4, 32'hFFFF_FFFE);
    rd_chk(1, "R6 set ignores upper bits");
    wr(4, 32'h1);
    rd_chk(1, "R6 sw set");
    rd_chk(4, "R6 word4 reads zero");
    wr(2, 32'h1);
    out_chk("R6 sw drives irq");
    wr(5, 32'hFFFF_FFFE);
    rd_chk(9, "R6 clr ignores upper bits");
    irq_lines = 32'h1;
    wr(5, 32'h1);
    rd_chk(1, "R1 hw line0 with sw cleared");
    out_chk("R1 hw line0");
    irq_lines = '0;
    wr(3, 32'hFFFF_FFFF);

    // R7 bad-offset writes, full sweep
    wr(2, 32'hA5A5_0F0F);
    wr(10, 32'h5A5A_F0F0);
    irq_lines = 32'h00FF_00FF;
    for (int a = 0; a < 16; a++) begin
      if (a inside {0, 1, 6, 7, 8, 9, 12, 13, 14, 15}) begin
        wr(a, 32'hFFFF_FFFF);
        rd_chk(2, "R7 bad write irq en");
        rd_chk(10, "R7 bad write fiq en");
        rd_chk(1, "R7 bad write raw");
      end
    end
    // R7 read sweep of every word
    for (int a = 0; a < 16; a++) rd_chk(a, "R7 read sweep");

    // pseudo-random patterns
    seed = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      seed = xs(seed); irq_lines = seed;
      seed = xs(seed); wr((seed[0]) ? 2 : 3, xs(seed));
      seed = xs(seed); wr((seed[1]) ? 10 : 11, xs(seed));
      if (seed[2]) wr(seed[3] ? 4 : 5, {31'd0, seed[4]});
      out_chk("R2 R3 pattern");
      rd_chk(0, "R5 pattern irq");
      rd_chk(8, "R5 pattern fiq");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule